// File: doc/BRIEF.md
# Multi-Scope Reset Sequencer

This block generates the reset outputs of an embedded processor chip. It supports three nested reset widths. The narrowest resets only the processor core. The middle one also resets the on-chip peripherals. The widest also resets every board device that shares the chip's open-drain reset net. A request of any width can come from the on-chip logic as a single-cycle strobe. The shared reset net can also be pulled low by an outside device. That pin is read through a two-stage synchronizer, and a low on it is handled as a system-wide reset.

The sequencer counts each pulse length on its single clock. It holds the core and peripheral resets until the clock generator reports a PLL lock. After those resets drop, it holds the external reset output to synchronous board peripherals until the peripheral clock is reported stable. When the chip starts a system reset itself, it drives the shared net low for a fixed long interval. It never adds its own drive to a low level applied from outside. After power-up the block behaves as if the shared net had been pulled low from outside.

Top module: `rstseq_top`

## Requirements
- R1: The resets are nested. `periph_rst` is never high without `core_rst`. `sysrst_drive_en` is never high without `core_rst`, `periph_rst` and `ext_rst`.
- R2: A `core_req` pulse accepted while idle holds `core_rst` high for exactly CORE_CYC cycles (default 16). It then releases without waiting for `pll_locked`. `periph_rst`, `ext_rst` and `sysrst_drive_en` stay low throughout.
- R3: A `chip_req` pulse asserts `core_rst`, `periph_rst` and `ext_rst` starting in the next cycle, for at least CORE_CYC cycles. After that count, `core_rst` and `periph_rst` drop one cycle after the first cycle in which `pll_locked` is sampled high.
- R4: A `sys_req` pulse drives `sysrst_drive_en` high for exactly SYS_CYC cycles (default 8192) and asserts all resets during that time. The PLL wait of R3 follows.
- R5: A low on `sysrst_pin_n` not caused by the block itself is seen two cycles later through the synchronizer. It starts a system-width reset with `sysrst_drive_en` kept low. The core and peripheral resets then stay high until the synchronized pin is high again. The PLL wait follows.
- R6: In a chip or system sequence, `ext_rst` stays high after `core_rst` and `periph_rst` release. It drops one cycle after the first cycle in that wait in which `perclk_stable` is sampled high.
- R7: `core_rst` and `periph_rst` release in the same cycle. `ext_rst` releases strictly later.
- R8: The widths rank as system (widest), then chip, then core. A request wider than the running sequence restarts the sequence at that width. A request of equal or narrower width is ignored. Simultaneous requests take the widest.
- R9: While the block drives the net, and for the synchronizer's latency afterwards, the low pin is not taken as an outside request.
- R10: After the synchronous `rst`, `core_rst`, `periph_rst` and `ext_rst` are high and `sysrst_drive_en` is low, as in R5. They later release through the PLL and peripheral-clock waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, used for both core and system cycle counts |
| rst | input | 1 | Synchronous active-high power-on reset |
| core_req | input | 1 | Core-width reset request strobe |
| chip_req | input | 1 | Chip-width reset request strobe |
| sys_req | input | 1 | System-width reset request strobe |
| sysrst_pin_n | input | 1 | Sensed level of the shared open-drain reset net, low active |
| pll_locked | input | 1 | PLL lock indication, synchronous |
| perclk_stable | input | 1 | Peripheral clock stable indication, synchronous |
| core_rst | output | 1 | Processor core reset, high active |
| periph_rst | output | 1 | On-chip peripheral reset, high active |
| sysrst_drive_en | output | 1 | Enable for the open-drain pull-down on the shared net |
| ext_rst | output | 1 | Reset to synchronous board peripherals, high active |

## Verification
The bench measures how many cycles each output stays high when the lock and clock-stable inputs arrive early, late, or later than the pulse count. A design that gated a core-only reset on PLL lock, or released the external reset together with the core reset, would show the wrong length. Restart cases cover a chip request during a core pulse, a core request during a chip pulse, and a system request during both a chip pulse and an outside pin hold. A wrong width ranking would show as a truncated or stretched core reset, or as the pull-down switching on against an outside low. The bench wires the pull-down back onto the sensed pin, so a design that mistook its own drive for an outside reset would lengthen the system sequence.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        SCOPE_NONE = 2'd0,
        SCOPE_CORE = 2'd1,
        SCOPE_CHIP = 2'd2,
        SCOPE_SYS  = 2'd3
    } scope_e;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_CORE_PULSE = 3'd1,
        ST_CHIP_PULSE = 3'd2,
        ST_SYS_DRIVE  = 3'd3,
        ST_PIN_HOLD   = 3'd4,
        ST_PLL_WAIT   = 3'd5,
        ST_PCLK_WAIT  = 3'd6
    } state_e;

    typedef struct packed {
        logic core;
        logic periph;
        logic drive;
        logic ext;
    } rst_vec_t;

    localparam int SYNC_STAGES = 2;

    function automatic logic [1:0] scope_rank(input scope_e s);
        return logic'(s[1]) ? {1'b1, s[0]} : {1'b0, s[0]};
    endfunction

    function automatic scope_e widest(input logic core, input logic chip, input logic sys);
        if (sys)       return SCOPE_SYS;
        else if (chip) return SCOPE_CHIP;
        else if (core) return SCOPE_CORE;
        else           return SCOPE_NONE;
    endfunction

    function automatic rst_vec_t decode_state(input state_e st);
        rst_vec_t v;
        v = '0;
        unique case (st)
            ST_IDLE:       v = '0;
            ST_CORE_PULSE: v.core = 1'b1;
            ST_CHIP_PULSE,
            ST_PIN_HOLD,
            ST_PLL_WAIT: begin
                v.core   = 1'b1;
                v.periph = 1'b1;
                v.ext    = 1'b1;
            end
            ST_SYS_DRIVE: begin
                v.core   = 1'b1;
                v.periph = 1'b1;
                v.drive  = 1'b1;
                v.ext    = 1'b1;
            end
            ST_PCLK_WAIT:  v.ext = 1'b1;
            default:       v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rstseq_pin_sync.sv
module rstseq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic drive_en,
    output logic ext_req
);
    logic [STAGES-1:0] sync_q;
    logic [STAGES-1:0] shadow_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[g]   <= 1'b0;
                    shadow_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g]   <= pin_n;
                    shadow_q[g] <= drive_en;
                end else begin
                    sync_q[g]   <= sync_q[(g == 0) ? 0 : g-1];
                    shadow_q[g] <= shadow_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    // A low seen while the own driver is on, or still in the sync pipe, is self-made
    assign ext_req = !sync_q[STAGES-1] && !drive_en && !(|shadow_q);

    AST_SELF_DRIVE_MASKED: assert property (@(posedge clk) disable iff (rst)
        drive_en |=> !ext_req); // R9

endmodule

// File: rtl/rstseq_arbiter.sv
module rstseq_arbiter
    import rstseq_pkg::*;
(
    input  logic   core_req,
    input  logic   chip_req,
    input  logic   sys_req,
    input  logic   ext_req,
    input  scope_e cur_scope,
    output scope_e req_scope,
    output logic   req_from_pin,
    output logic   accept
);
    always_comb begin
        req_scope    = widest(core_req, chip_req, sys_req || ext_req);
        req_from_pin = ext_req;
        accept       = scope_rank(req_scope) > scope_rank(cur_scope);
    end

    always_comb begin
        if (accept) begin
            AST_ACCEPT_NONEMPTY: assert (req_scope != SCOPE_NONE); // R8
        end
    end

endmodule

// File: rtl/rstseq_engine.sv
module rstseq_engine
    import rstseq_pkg::*;
#(
    parameter int CORE_CYC = 16,
    parameter int SYS_CYC  = 8192
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  scope_e   req_scope,
    input  logic     req_from_pin,
    input  logic     ext_req,
    input  logic     pll_locked,
    input  logic     perclk_stable,
    output scope_e   cur_scope,
    output rst_vec_t rst_vec
);
    localparam int MAXC = (SYS_CYC > CORE_CYC) ? SYS_CYC : CORE_CYC;
    localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] CORE_LOAD = CW'(CORE_CYC - 1);
    localparam logic [CW-1:0] SYS_LOAD  = CW'(SYS_CYC - 1);

    state_e        state_q, state_d;
    scope_e        scope_q, scope_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        scope_d = scope_q;
        cnt_d   = cnt_q;
        if (accept) begin
            scope_d = req_scope;
            unique case (req_scope)
                SCOPE_CORE: begin
                    state_d = ST_CORE_PULSE;
                    cnt_d   = CORE_LOAD;
                end
                SCOPE_CHIP: begin
                    state_d = ST_CHIP_PULSE;
                    cnt_d   = CORE_LOAD;
                end
                SCOPE_SYS: begin
                    state_d = req_from_pin ? ST_PIN_HOLD : ST_SYS_DRIVE;
                    cnt_d   = SYS_LOAD;
                end
                default: ;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: scope_d = SCOPE_NONE;
                ST_CORE_PULSE: begin
                    if (cnt_q == '0) begin
                        state_d = ST_IDLE;
                        scope_d = SCOPE_NONE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_CHIP_PULSE,
                ST_SYS_DRIVE: begin
                    if (cnt_q == '0) state_d = ST_PLL_WAIT;
                    else             cnt_d   = cnt_q - 1'b1;
                end
                ST_PIN_HOLD: begin
                    if (!ext_req) state_d = ST_PLL_WAIT;
                end
                ST_PLL_WAIT: begin
                    if (pll_locked) state_d = ST_PCLK_WAIT;
                end
                ST_PCLK_WAIT: begin
                    if (perclk_stable) begin
                        state_d = ST_IDLE;
                        scope_d = SCOPE_NONE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    scope_d = SCOPE_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PIN_HOLD;
            scope_q <= SCOPE_SYS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            scope_q <= scope_d;
            cnt_q   <= cnt_d;
        end
    end

    assign cur_scope = scope_q;
    assign rst_vec   = decode_state(state_q);

    AST_CORE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CORE_PULSE || state_q == ST_CHIP_PULSE) |-> cnt_q <= CORE_LOAD); // R2
    AST_PLL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PLL_WAIT && !pll_locked && !accept) |=> state_q == ST_PLL_WAIT); // R3
    AST_PIN_HOLD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PIN_HOLD && ext_req) |=> state_q == ST_PIN_HOLD); // R5
    AST_SCOPE_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (scope_q != SCOPE_NONE && state_q != ST_IDLE && !(state_q == ST_CORE_PULSE && cnt_q == '0)
         && state_q != ST_PCLK_WAIT)
        |=> scope_rank(scope_q) >= scope_rank($past(scope_q))); // R8

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int CORE_CYC = 16,
    parameter int SYS_CYC  = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic core_req,
    input  logic chip_req,
    input  logic sys_req,
    input  logic sysrst_pin_n,
    input  logic pll_locked,
    input  logic perclk_stable,
    output logic core_rst,
    output logic periph_rst,
    output logic sysrst_drive_en,
    output logic ext_rst
);
    localparam int LW = $clog2(SYS_CYC + 1) + 1;

    logic     ext_req;
    logic     accept;
    logic     req_from_pin;
    scope_e   req_scope;
    scope_e   cur_scope;
    rst_vec_t rst_vec;

    rstseq_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst      (rst),
        .pin_n    (sysrst_pin_n),
        .drive_en (rst_vec.drive),
        .ext_req  (ext_req)
    );

    rstseq_arbiter u_arb (
        .core_req     (core_req),
        .chip_req     (chip_req),
        .sys_req      (sys_req),
        .ext_req      (ext_req),
        .cur_scope    (cur_scope),
        .req_scope    (req_scope),
        .req_from_pin (req_from_pin),
        .accept       (accept)
    );

    rstseq_engine #(.CORE_CYC(CORE_CYC), .SYS_CYC(SYS_CYC)) u_eng (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .req_scope     (req_scope),
        .req_from_pin  (req_from_pin),
        .ext_req       (ext_req),
        .pll_locked    (pll_locked),
        .perclk_stable (perclk_stable),
        .cur_scope     (cur_scope),
        .rst_vec       (rst_vec)
    );

    assign core_rst        = rst_vec.core;
    assign periph_rst      = rst_vec.periph;
    assign sysrst_drive_en = rst_vec.drive;
    assign ext_rst         = rst_vec.ext;

    // Run-length counters used only by the assertions below
    logic [LW-1:0] core_len_q;
    logic [LW-1:0] drv_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            core_len_q <= '0;
            drv_len_q  <= '0;
        end else begin
            core_len_q <= !core_rst ? '0 : ((&core_len_q) ? core_len_q : core_len_q + 1'b1);
            drv_len_q  <= !sysrst_drive_en ? '0 : ((&drv_len_q) ? drv_len_q : drv_len_q + 1'b1);
        end
    end

    AST_NESTED_PERIPH: assert property (@(posedge clk) disable iff (rst)
        periph_rst |-> core_rst); // R1
    AST_NESTED_DRIVE: assert property (@(posedge clk) disable iff (rst)
        sysrst_drive_en |-> (core_rst && periph_rst && ext_rst)); // R1
    AST_CORE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_rst) && !$past(periph_rst)) |-> core_len_q == LW'(CORE_CYC)); // R2
    AST_PLL_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(periph_rst) |-> $past(pll_locked)); // R3
    AST_DRIVE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(sysrst_drive_en) |-> drv_len_q == LW'(SYS_CYC)); // R4
    AST_DRIVE_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(sysrst_drive_en) |-> $past(sys_req)); // R5
    AST_PERCLK_GATE: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_rst) |-> $past(perclk_stable)); // R6
    AST_EXT_LAST: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_rst) |-> (!core_rst && !periph_rst && !$past(core_rst))); // R7

endmodule

// File: tb/rstseq_top_test.sv
module rstseq_top_test;

    localparam int CORE_CYC = 16;
    localparam int SYS_CYC  = 8192;
    localparam int NV = 10;
    // kind: 0 = outside pin pull (arg = low edges), 1 = core, 2 = chip, 3 = system
    localparam int V_KIND [NV] = '{1, 1, 2, 2, 2, 2, 3, 3, 0, 0};
    localparam int V_ARG  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 5, 40};
    localparam int V_PLL  [NV] = '{0, 50, 0, 40, 0, 30, 0, 9000, 0, 10};
    localparam int V_PC   [NV] = '{0, 50, 0, 0, 60, 35, 0, 9100, 0, 70};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic core_req = 1'b0, chip_req = 1'b0, sys_req = 1'b0;
    logic ext_pull = 1'b0;
    logic pll_locked = 1'b0, perclk_stable = 1'b0;
    logic sysrst_pin_n;
    logic core_rst, periph_rst, sysrst_drive_en, ext_rst;

    int n_checks = 0;
    int n_fail   = 0;
    int n_core, n_per, n_ext, n_drv, last_core, last_ext;

    assign sysrst_pin_n = !(sysrst_drive_en || ext_pull);

    always #5 clk = ~clk;

    rstseq_top #(.CORE_CYC(CORE_CYC), .SYS_CYC(SYS_CYC)) uut (
        .clk             (clk),
        .rst             (rst),
        .core_req        (core_req),
        .chip_req        (chip_req),
        .sys_req         (sys_req),
        .sysrst_pin_n    (sysrst_pin_n),
        .pll_locked      (pll_locked),
        .perclk_stable   (perclk_stable),
        .core_rst        (core_rst),
        .periph_rst      (periph_rst),
        .sysrst_drive_en (sysrst_drive_en),
        .ext_rst         (ext_rst)
    );

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Cycle k is the interval after the k-th rising edge following the request set-up.
    task automatic run_seq(input int core_at, input int chip_at, input int sys_at,
                           input int pin_len, input int pll_at, input int pc_at);
        int start_k;
        int quiet;
        n_core = 0; n_per = 0; n_ext = 0; n_drv = 0;
        last_core = -1; last_ext = -1;
        quiet = 0;
        start_k = mx(mx(core_at, chip_at), mx(sys_at, pin_len)) + 4;
        @(negedge clk);
        pll_locked    = 1'b0;
        perclk_stable = 1'b0;
        core_req = (core_at == 0);
        chip_req = (chip_at == 0);
        sys_req  = (sys_at == 0);
        ext_pull = (pin_len > 0);
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (core_rst)        begin n_core++; last_core = k; end
            if (periph_rst)      n_per++;
            if (ext_rst)         begin n_ext++; last_ext = k; end
            if (sysrst_drive_en) n_drv++;
            if (!core_rst && !periph_rst && !ext_rst && !sysrst_drive_en) quiet++;
            else quiet = 0;
            core_req      = (core_at == k + 1);
            chip_req      = (chip_at == k + 1);
            sys_req       = (sys_at == k + 1);
            ext_pull      = (k + 1 < pin_len);
            pll_locked    = (k >= pll_at);
            perclk_stable = (k >= pc_at);
            if (k >= start_k && quiet >= 3) break;
        end
        core_req = 1'b0; chip_req = 1'b0; sys_req = 1'b0; ext_pull = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int ec, ep, ee, ed, rel;
        // R10: power-up state
        repeat (3) @(negedge clk);
        check("R10 core_rst in reset", int'(core_rst), 1);
        check("R10 periph_rst in reset", int'(periph_rst), 1);
        check("R10 ext_rst in reset", int'(ext_rst), 1);
        check("R10 drive off in reset", int'(sysrst_drive_en), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 core held for PLL", int'(core_rst), 1);
        check("R10 ext held", int'(ext_rst), 1);
        check("R10 no self drive", int'(sysrst_drive_en), 0);
        pll_locked = 1'b1;
        perclk_stable = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 all released", int'(core_rst || periph_rst || ext_rst || sysrst_drive_en), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            unique case (V_KIND[v])
                1: run_seq(0, -1, -1, 0, V_PLL[v], V_PC[v]);
                2: run_seq(-1, 0, -1, 0, V_PLL[v], V_PC[v]);
                3: run_seq(-1, -1, 0, 0, V_PLL[v], V_PC[v]);
                default: run_seq(-1, -1, -1, V_ARG[v], V_PLL[v], V_PC[v]);
            endcase
            unique case (V_KIND[v])
                1: begin ec = CORE_CYC; ep = 0; ee = 0; ed = 0; end
                2: begin
                    ec = mx(CORE_CYC, V_PLL[v]) + 1; ep = ec;
                    ee = mx(ec, V_PC[v]) + 1; ed = 0;
                end
                3: begin
                    ec = mx(SYS_CYC, V_PLL[v]) + 1; ep = ec;
                    ee = mx(ec, V_PC[v]) + 1; ed = SYS_CYC;
                end
                default: begin
                    rel = mx(V_ARG[v] + 2, V_PLL[v]) + 1;
                    ec = rel - 2; ep = ec;
                    ee = mx(rel, V_PC[v]) + 1 - 2; ed = 0;
                end
            endcase
            check($sformatf("R2/R3/R4/R5 vec%0d core_rst cycles", v), n_core, ec);
            check($sformatf("R1/R2/R3 vec%0d periph_rst cycles", v), n_per, ep);
            check($sformatf("R6 vec%0d ext_rst cycles", v), n_ext, ee);
            check($sformatf("R4/R5/R9 vec%0d drive cycles", v), n_drv, ed);
            if (V_KIND[v] != 1)
                check($sformatf("R7 vec%0d ext released last", v), int'(last_ext > last_core), 1);
        end

        // R8: chip request during a core pulse restarts wider
        run_seq(0, 5, -1, 0, 0, 0);
        check("R8 core->chip core cycles", n_core, 22);
        check("R8 core->chip periph cycles", n_per, 17);
        check("R8 core->chip ext cycles", n_ext, 18);
        // R8: core request during a chip pulse is ignored
        run_seq(5, 0, -1, 0, 0, 0);
        check("R8 chip+late core core cycles", n_core, 17);
        check("R8 chip+late core ext cycles", n_ext, 18);
        // R8: simultaneous requests take the widest
        run_seq(0, 0, -1, 0, 0, 0);
        check("R8 simultaneous periph cycles", n_per, 17);
        check("R8 simultaneous core cycles", n_core, 17);
        // R5 R8: system request during an outside pin hold leaves the driver off
        run_seq(-1, -1, 4, 20, 0, 0);
        check("R5 pin hold sys_req drive cycles", n_drv, 0);
        check("R5 pin hold core cycles", n_core, 21);
        check("R5 pin hold ext cycles", n_ext, 22);
        // R8 R4: system request during a chip pulse restarts with the driver
        run_seq(-1, 0, 8, 0, 0, 0);
        check("R8 chip->sys drive cycles", n_drv, SYS_CYC);
        check("R8 chip->sys core cycles", n_core, SYS_CYC + 9);
        check("R8 chip->sys ext cycles", n_ext, SYS_CYC + 10);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule